// File: doc/BRIEF.md
# Secure Doorbell Mailbox

This unit carries interrupt doorbells between an application processor and a system control processor. There is one secure channel in each direction. Every channel holds a 32-bit status word. Bits 0 to 30 are doorbell slots. Bit 31 is a sticky flag that hardware raises when an access arrives without the security attribute.

A sender sets one or more slot bits by writing ones to the channel's set address. The receiver sees its interrupt line rise. It reads the status word, handles the slots, and acknowledges each one by writing ones to the clear address. Before the sender reuses a slot, it polls the status word until that slot reads back as clear.

The register port is a simple single-cycle bus. It carries an address, a write enable, write data and a security attribute, and it returns registered read data.

Top module: `mbx_doorbell`

## Requirements
- R1: While reset is held, and after reset is released, both status words read as zero, both interrupt outputs are low and read data is zero.
- R2: A secure write to a channel's set address (processor-to-controller 0x308, controller-to-processor 0x208) sets each status bit n, for n in 0..30, where write data bit n is 1. All other bits keep their values.
- R3: A secure write to a channel's clear address (0x310 or 0x210) clears each status bit n, for n in 0..31, where write data bit n is 1. All other bits keep their values. This is the only way to clear bit 31.
- R4: Bit 31 of write data has no effect when written through a set address.
- R5: A non-secure write to any of a channel's three addresses (status 0x300/0x200, set, clear) leaves bits 0..30 unchanged and sets bit 31 of that channel only.
- R6: When the secure attribute is high and the address is a status address (0x300 or 0x200), read data shows that status word one clock edge later. In every other case read data is zero: a set address, a clear address, an unmapped address, or the secure attribute low.
- R7: Each interrupt output is the OR of status bits 0..30 of its channel, registered once. irq_to_ctrl follows the 0x300 channel and irq_to_app follows the 0x200 channel.
- R8: A secure write to a status address has no effect.
- R9: A write addressed to one channel never changes the other channel's status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 12 | Register byte offset |
| reg_we | input | 1 | Write enable |
| reg_wdata | input | 32 | Write data |
| reg_secure | input | 1 | Security attribute of the current access |
| reg_rdata | output | 32 | Registered read data |
| irq_to_ctrl | output | 1 | Doorbell interrupt toward the control processor |
| irq_to_app | output | 1 | Doorbell interrupt toward the application processor |

## Verification
The hardest state to reach from the ports has bit 31 set by a violation while doorbell slots are still pending. In that state the interrupt must keep tracking only the slots, and clearing the flag must leave them alone. The stimulus first loads a multi-bit slot pattern with secure set writes. It then issues non-secure writes to each of the channel's three addresses. Finally it clears bit 31 with a secure clear write, and it reads back both channels after every step.

// File: rtl/mbx_doorbell.sv
module mbx_doorbell #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter logic [ADDR_W-1:0] P2C_BASE = 12'h300,
  parameter logic [ADDR_W-1:0] C2P_BASE = 12'h200,
  parameter logic [ADDR_W-1:0] SET_OFS  = 12'h008,
  parameter logic [ADDR_W-1:0] CLR_OFS  = 12'h010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_secure,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_to_ctrl,
  output logic              irq_to_app
);
  localparam int FLAG = DATA_W - 1;
  localparam logic [DATA_W-1:0] FLAG_MASK = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] stat_p2c, stat_c2p;

  function automatic logic [DATA_W-1:0] next_stat(
    input logic [DATA_W-1:0] cur,
    input logic [ADDR_W-1:0] base,
    input logic [ADDR_W-1:0] addr,
    input logic              we,
    input logic              sec,
    input logic [DATA_W-1:0] wd
  );
    logic hit_set, hit_clr, hit_any;
    logic [DATA_W-1:0] set_m, clr_m;
    hit_set = we && (addr == base + SET_OFS);
    hit_clr = we && (addr == base + CLR_OFS);
    hit_any = hit_set || hit_clr || (we && (addr == base));
    set_m   = hit_set ? (wd & ~FLAG_MASK) : '0;
    clr_m   = hit_clr ? wd : '0;
    if (!hit_any)  return cur;
    if (!sec)      return cur | FLAG_MASK;
    return (cur & ~clr_m) | set_m;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_p2c    <= '0;
      stat_c2p    <= '0;
      irq_to_ctrl <= 1'b0;
      irq_to_app  <= 1'b0;
      reg_rdata   <= '0;
    end else begin
      stat_p2c    <= next_stat(stat_p2c, P2C_BASE, reg_addr, reg_we, reg_secure, reg_wdata);
      stat_c2p    <= next_stat(stat_c2p, C2P_BASE, reg_addr, reg_we, reg_secure, reg_wdata);
      irq_to_ctrl <= |stat_p2c[FLAG-1:0];
      irq_to_app  <= |stat_c2p[FLAG-1:0];
      if (reg_secure && reg_addr == P2C_BASE)      reg_rdata <= stat_p2c;
      else if (reg_secure && reg_addr == C2P_BASE) reg_rdata <= stat_c2p;
      else                                         reg_rdata <= '0;
    end
  end
endmodule

module mbx_doorbell_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] P2C_BASE = 12'h300,
  parameter logic [ADDR_W-1:0] C2P_BASE = 12'h200,
  parameter logic [ADDR_W-1:0] SET_OFS  = 12'h008,
  parameter logic [ADDR_W-1:0] CLR_OFS  = 12'h010
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              reg_secure,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq_to_ctrl,
  input logic              irq_to_app,
  input logic [DATA_W-1:0] stat_p2c,
  input logic [DATA_W-1:0] stat_c2p
);
  localparam int FLAG = DATA_W - 1;

  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |=> (stat_p2c == '0 && stat_c2p == '0 && !irq_to_ctrl && !irq_to_app));

  p_set_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_secure && reg_addr == P2C_BASE + SET_OFS)
    |=> ((stat_p2c[FLAG-1:0] & $past(reg_wdata[FLAG-1:0])) == $past(reg_wdata[FLAG-1:0])));

  p_clr_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_secure && reg_addr == C2P_BASE + CLR_OFS)
    |=> ((stat_c2p & $past(reg_wdata)) == '0));

  p_flag_no_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_secure && reg_addr == P2C_BASE + SET_OFS)
    |=> (stat_p2c[FLAG] == $past(stat_p2c[FLAG])));

  p_ns_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_secure && reg_addr == P2C_BASE + SET_OFS)
    |=> (stat_p2c[FLAG] && stat_p2c[FLAG-1:0] == $past(stat_p2c[FLAG-1:0])));

  p_ns_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_secure |=> (reg_rdata == '0));

  p_irq_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_to_app == |$past(stat_c2p[FLAG-1:0])));

  p_other_chan_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == P2C_BASE + CLR_OFS) |=> $stable(stat_c2p));
endmodule

bind mbx_doorbell mbx_doorbell_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_secure(reg_secure), .reg_rdata(reg_rdata),
  .irq_to_ctrl(irq_to_ctrl), .irq_to_app(irq_to_app),
  .stat_p2c(stat_p2c), .stat_c2p(stat_c2p)
);

// File: tb/mbx_doorbell_tb.sv
`timescale 1ns/1ps
module mbx_doorbell_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_secure = 1'b0;
  logic [31:0] reg_rdata;
  logic        irq_to_ctrl, irq_to_app;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] exp_st [2];
  logic [11:0] base [2];

  always #4 clk = ~clk;

  mbx_doorbell u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_secure(reg_secure), .reg_rdata(reg_rdata),
    .irq_to_ctrl(irq_to_ctrl), .irq_to_app(irq_to_app)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic model_wr(input logic [11:0] a, input logic [31:0] d, input logic sec);
    for (int c = 0; c < 2; c++) begin
      if (a == base[c] || a == base[c] + 12'h8 || a == base[c] + 12'h10) begin
        if (!sec) exp_st[c][31] = 1'b1;
        else if (a == base[c] + 12'h8) exp_st[c] = exp_st[c] | {1'b0, d[30:0]};
        else if (a == base[c] + 12'h10) exp_st[c] = exp_st[c] & ~d;
      end
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic sec);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_secure = sec; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_secure = 1'b1; reg_addr = 12'hffc;
    model_wr(a, d, sec);
  endtask

  task automatic rd(input logic [11:0] a, input logic sec, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a; reg_secure = sec; reg_we = 1'b0;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic verify(input string req);
    logic [31:0] v;
    rd(base[0], 1'b1, v);
    check(req, v, exp_st[0]);
    check({req, " R7 irq_to_ctrl"}, {31'b0, irq_to_ctrl}, {31'b0, |exp_st[0][30:0]});
    check({req, " R7 irq_to_app"}, {31'b0, irq_to_app}, {31'b0, |exp_st[1][30:0]});
    rd(base[1], 1'b1, v);
    check({req, " R9"}, v, exp_st[1]);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    base[0] = 12'h300; base[1] = 12'h200;
    exp_st[0] = '0; exp_st[1] = '0;
    repeat (3) @(negedge clk);
    check("R1 rdata in reset", reg_rdata, 32'h0);
    check("R1 irq in reset", {30'b0, irq_to_ctrl, irq_to_app}, 32'h0);
    rst_n = 1'b1;
    verify("R1 after reset");

    for (int c = 0; c < 2; c++) begin
      for (int s = 0; s < 31; s++) begin
        wr(base[c] + 12'h8, 32'h1 << s, 1'b1);
        verify("R2 single slot set");
        wr(base[c] + 12'h10, 32'h1 << s, 1'b1);
        verify("R3 single slot clear");
      end
    end

    wr(12'h308, 32'h5555_5555, 1'b1);
    wr(12'h308, 32'h2aaa_0000, 1'b1);
    verify("R2 pattern OR");
    wr(12'h310, 32'h0f0f_0f0f, 1'b1);
    verify("R3 pattern clear");
    wr(12'h308, 32'h8000_0000, 1'b1);
    verify("R4 flag via set");
    wr(12'h300, 32'hffff_ffff, 1'b1);
    verify("R8 secure status write");

    wr(12'h208, 32'h0000_00f0, 1'b1);
    for (int k = 0; k < 3; k++) begin
      wr(12'h300 + 12'(k * 8), 32'hffff_ffff, 1'b0);
      verify("R5 nonsecure write p2c");
    end
    check("R5 flag raised", {31'b0, exp_st[0][31]}, 32'h1);
    wr(12'h210, 32'hffff_ffff, 1'b0);
    verify("R5 nonsecure write c2p");

    rd(12'h300, 1'b0, v); check("R6 nonsecure read", v, 32'h0);
    rd(12'h308, 1'b1, v); check("R6 set addr read", v, 32'h0);
    rd(12'h210, 1'b1, v); check("R6 clear addr read", v, 32'h0);
    rd(12'h100, 1'b1, v); check("R6 unmapped read", v, 32'h0);

    wr(12'h310, 32'h8000_0000, 1'b1);
    verify("R3 flag clear keeps slots");
    wr(12'h210, 32'hffff_ffff, 1'b1);
    wr(12'h310, 32'hffff_ffff, 1'b1);
    verify("R3 full clear");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule